// File: doc/BRIEF.md
# PAE Top-Level Pointer Entry Loader

This block keeps the four 64-bit top-level translation pointers that a 32-bit physical-address-extension walk starts from. Each pointer lives in a private register, not in architectural state. When certain control-register events occur, the block refills all four registers from memory. It issues four single-word reads, one after another, starting at the table base taken from CR3.

Each word is classified as it arrives. A word whose present bit is clear is marked as neither valid nor faulting. A present word with any reserved bit set is marked as faulting, so a later lookup through it can raise a page fault. A present, clean word is marked valid.

The memory side is a plain request/valid read port with one outstanding read. A new reload event during a refill restarts the refill from pointer 0 with the current CR3 base.

Top module: `pdpt_loader`

## Requirements
- R1: Pointer i is read from address {cr3_i[31:5], i[1:0], 3'b000}, zero-extended to PA_W bits, in the order 0, 1, 2, 3. `rd_req_o` and `rd_addr_o` hold steady until `rd_valid_i` accepts the word, and there is only one read in flight at a time.
- R2: A pulse on `cr3_wr_i` starts a refill only in PAE mode, that is when `paging_en_i`=1, `pae_en_i`=1 and `long_mode_i`=0. Outside that mode the pulse is ignored: there are no reads and the pointers are unchanged.
- R3: A pulse on `task_sw_i` follows the same rule as R2. It starts a refill in PAE mode and is ignored otherwise.
- R4: A pulse on `ctl_wr_i` starts a refill only when `ctl_old_i` and `ctl_new_i` differ in at least one of bits 6:0 and the mode inputs show PAE mode. Equal vectors, or a change outside PAE mode, start nothing.
- R5: The cycle after a starting event, `busy_o` is 1 and all `ent_vld_o` and `ent_flt_o` bits are 0. `busy_o` falls in the cycle after the fourth word is accepted.
- R6: The accepted word is stored whole in `ent_o[i]`. The present flag is bit 0. Reserved bits are 2:1, 8:5 and 63:PA_W; bits 3, 4 and 11:9 are free. `ent_vld_o[i]` = present and no reserved bit set. `ent_flt_o[i]` = present and some reserved bit set. The two flags are never both 1.
- R7: A starting event during a refill restarts it: the next read goes to pointer 0 of the base then on `cr3_i`, and the final contents come from that base.
- R8: Without a starting event, the stored pointers and flags do not change, and no read is requested once a refill ends.
- R9: After reset, `busy_o`, `rd_req_o`, every flag and every stored pointer are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cr3_i | input | 32 | Current CR3 value; bits 31:5 give the table base |
| paging_en_i | input | 1 | Paging enabled |
| pae_en_i | input | 1 | Physical address extension enabled |
| long_mode_i | input | 1 | Long mode active (PAE mode excluded) |
| cr3_wr_i | input | 1 | Pulse: CR3 written |
| task_sw_i | input | 1 | Pulse: task switch loaded CR3 |
| ctl_wr_i | input | 1 | Pulse: CR0 or CR4 written |
| ctl_old_i | input | 7 | Watched control bits before the write |
| ctl_new_i | input | 7 | Watched control bits after the write |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | PA_W | Read byte address |
| rd_valid_i | input | 1 | Read data valid for the current address |
| rd_data_i | input | 64 | Read data |
| ent_o | output | 4x64 | Stored pointer words |
| ent_vld_o | output | 4 | Pointer present and well formed |
| ent_flt_o | output | 4 | Pointer present with a reserved bit set |
| busy_o | output | 1 | Refill in progress |

## Verification
The assertions check, every cycle, the properties that hold locally:
- the read address holds while a request waits;
- a starting event clears the flags and moves the address back to pointer 0;
- busy ends after the last word;
- the valid and fault flags never rise together;
- idle slots hold their contents;
- a refill begins only in PAE mode.

Only the bench scenarios can show the rest:
- that the read addresses match the CR3 base;
- that each stored word is classified correctly against the reserved-bit rules;
- that each trigger source is gated correctly;
- that a refill restarted midway ends with the second table's contents.

// File: rtl/pdpt_pkg.sv
package pdpt_pkg;
  localparam int WORD_W = 64;
  localparam int CTL_W  = 7;
  localparam int CR3_W  = 32;

  typedef enum logic {ST_IDLE = 1'b0, ST_LOAD = 1'b1} ld_state_e;

  // reserved bits of a present pointer word for a given physical width
  function automatic logic [WORD_W-1:0] rsv_mask(input int pa_w);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int b = 0; b < WORD_W; b++) begin
      if (b >= pa_w) m[b] = 1'b1;
    end
    m[2:1] = 2'b11;
    m[8:5] = 4'b1111;
    return m;
  endfunction
endpackage

// File: rtl/pdpt_trig.sv
module pdpt_trig
  import pdpt_pkg::*;
(
  input  logic             paging_en_i,
  input  logic             pae_en_i,
  input  logic             long_mode_i,
  input  logic             cr3_wr_i,
  input  logic             task_sw_i,
  input  logic             ctl_wr_i,
  input  logic [CTL_W-1:0] ctl_old_i,
  input  logic [CTL_W-1:0] ctl_new_i,
  output logic             pae_mode_o,
  output logic             trig_o
);
  logic ctl_chg;

  assign pae_mode_o = paging_en_i & pae_en_i & ~long_mode_i;
  assign ctl_chg    = ctl_wr_i & (|(ctl_old_i ^ ctl_new_i));
  assign trig_o     = pae_mode_o & (cr3_wr_i | task_sw_i | ctl_chg);
endmodule

// File: rtl/pdpt_chk.sv
module pdpt_chk
  import pdpt_pkg::*;
#(
  parameter int PA_W = 36
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              ok_o,
  output logic              bad_o
);
  localparam logic [WORD_W-1:0] RSV = rsv_mask(PA_W);
  logic rsv_hit;

  assign rsv_hit = |(word_i & RSV);
  assign ok_o    = word_i[0] & ~rsv_hit;
  assign bad_o   = word_i[0] & rsv_hit;
endmodule

// File: rtl/pdpt_seq.sv
module pdpt_seq
  import pdpt_pkg::*;
#(
  parameter int PA_W  = 36,
  parameter int N_ENT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic [CR3_W-1:0] cr3_i,
  input  logic             rd_valid_i,
  output logic             rd_req_o,
  output logic [PA_W-1:0]  rd_addr_o,
  output logic             wr_en_o,
  output logic [$clog2(N_ENT)-1:0] wr_idx_o,
  output logic             busy_o
);
  localparam int IDX_W  = $clog2(N_ENT);
  localparam int OFS_W  = IDX_W + 3;
  localparam int BASE_W = CR3_W - OFS_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

  ld_state_e          st_q;
  logic [IDX_W-1:0]   idx_q;
  logic [BASE_W-1:0]  base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      base_q <= '0;
    end else if (trig_i) begin
      st_q   <= ST_LOAD;
      idx_q  <= '0;
      base_q <= cr3_i[CR3_W-1:OFS_W];
    end else if (st_q == ST_LOAD && rd_valid_i) begin
      if (idx_q == LAST) st_q <= ST_IDLE;
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign rd_req_o  = (st_q == ST_LOAD);
  assign rd_addr_o = PA_W'({base_q, idx_q, 3'b000});
  assign wr_en_o   = (st_q == ST_LOAD) & rd_valid_i & ~trig_i;
  assign wr_idx_o  = idx_q;
  assign busy_o    = (st_q == ST_LOAD);

  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_valid_i && !trig_i |=> rd_req_o && rd_addr_o == $past(rd_addr_o)); // R1
  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> busy_o && rd_addr_o[OFS_W-1:0] == '0); // R7
  AST_LAST_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && rd_valid_i && !trig_i && rd_addr_o[OFS_W-1:3] == LAST |=> !busy_o); // R5
endmodule

// File: rtl/pdpt_slot.sv
module pdpt_slot
  import pdpt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              ok_i,
  input  logic              bad_i,
  output logic [WORD_W-1:0] data_o,
  output logic              vld_o,
  output logic              flt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      vld_o  <= 1'b0;
      flt_o  <= 1'b0;
    end else if (clr_i) begin
      vld_o  <= 1'b0;
      flt_o  <= 1'b0;
    end else if (we_i) begin
      data_o <= wdata_i;
      vld_o  <= ok_i;
      flt_o  <= bad_i;
    end
  end

  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vld_o && flt_o)); // R6
  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !vld_o && !flt_o); // R5
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && !we_i |=> $stable(data_o) && $stable(vld_o) && $stable(flt_o)); // R8
endmodule

// File: rtl/pdpt_loader.sv
module pdpt_loader
  import pdpt_pkg::*;
#(
  parameter int PA_W  = 36,
  parameter int N_ENT = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [31:0]                   cr3_i,
  input  logic                          paging_en_i,
  input  logic                          pae_en_i,
  input  logic                          long_mode_i,
  input  logic                          cr3_wr_i,
  input  logic                          task_sw_i,
  input  logic                          ctl_wr_i,
  input  logic [6:0]                    ctl_old_i,
  input  logic [6:0]                    ctl_new_i,
  output logic                          rd_req_o,
  output logic [PA_W-1:0]               rd_addr_o,
  input  logic                          rd_valid_i,
  input  logic [63:0]                   rd_data_i,
  output logic [N_ENT-1:0][63:0]        ent_o,
  output logic [N_ENT-1:0]              ent_vld_o,
  output logic [N_ENT-1:0]              ent_flt_o,
  output logic                          busy_o
);
  localparam int IDX_W = $clog2(N_ENT);

  logic             pae_mode, trig;
  logic             wr_en, w_ok, w_bad;
  logic [IDX_W-1:0] wr_idx;

  pdpt_trig u_trig (
    .paging_en_i (paging_en_i),
    .pae_en_i    (pae_en_i),
    .long_mode_i (long_mode_i),
    .cr3_wr_i    (cr3_wr_i),
    .task_sw_i   (task_sw_i),
    .ctl_wr_i    (ctl_wr_i),
    .ctl_old_i   (ctl_old_i),
    .ctl_new_i   (ctl_new_i),
    .pae_mode_o  (pae_mode),
    .trig_o      (trig)
  );

  pdpt_seq #(.PA_W(PA_W), .N_ENT(N_ENT)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig),
    .cr3_i      (cr3_i),
    .rd_valid_i (rd_valid_i),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .busy_o     (busy_o)
  );

  pdpt_chk #(.PA_W(PA_W)) u_chk (
    .word_i (rd_data_i),
    .ok_o   (w_ok),
    .bad_o  (w_bad)
  );

  for (genvar g = 0; g < N_ENT; g++) begin : g_slot
    pdpt_slot u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (trig),
      .we_i    (wr_en && wr_idx == IDX_W'(g)),
      .wdata_i (rd_data_i),
      .ok_i    (w_ok),
      .bad_i   (w_bad),
      .data_o  (ent_o[g]),
      .vld_o   (ent_vld_o[g]),
      .flt_o   (ent_flt_o[g])
    );
  end

  AST_START_IN_PAE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(pae_mode)); // R2
endmodule

// File: tb/tb_pdpt_loader.sv
`timescale 1ns/1ps
module tb_pdpt_loader;
  localparam int PA_W = 36;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [31:0] cr3_i = '0;
  logic paging_en_i = 1'b1, pae_en_i = 1'b1, long_mode_i = 1'b0;
  logic cr3_wr_i = 1'b0, task_sw_i = 1'b0, ctl_wr_i = 1'b0;
  logic [6:0] ctl_old_i = '0, ctl_new_i = '0;
  logic rd_req_o;
  logic [PA_W-1:0] rd_addr_o;
  logic rd_valid_i = 1'b0;
  logic [63:0] rd_data_i = '0;
  logic [3:0][63:0] ent_o;
  logic [3:0] ent_vld_o, ent_flt_o;
  logic busy_o;

  always #2 clk = ~clk;

  pdpt_loader #(.PA_W(PA_W)) dut (.*, .clk_i(clk));

  int n_tot = 0, n_fail = 0;
  logic [63:0] mem [128];
  logic [PA_W-1:0] alog [256];
  int nlog = 0;
  int lat = 1;

  // {vld, flt, word}, grouped four per table
  localparam logic [65:0] VEC [12] = '{
    {2'b10, 64'h0000_0000_1234_5001}, {2'b00, 64'h0000_0000_0000_0000},
    {2'b10, 64'h0000_0000_0ABC_D019}, {2'b01, 64'h0000_0000_0000_1003},
    {2'b01, 64'h0000_0010_0000_2001}, {2'b10, 64'h0000_0008_0000_3001},
    {2'b01, 64'h8000_0000_0000_0001}, {2'b01, 64'h0000_0000_0000_0021},
    {2'b10, 64'h0000_0000_0000_0E01}, {2'b00, 64'hFFFF_FFFF_FFFF_FFFE},
    {2'b01, 64'h0000_0000_0000_0101}, {2'b01, 64'h0000_0000_000F_F005}};
  localparam logic [31:0] CR3S [3] = '{32'h0000_011F, 32'h8000_0120, 32'h0000_03E7};

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tot++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [PA_W-1:0] exp_addr(input logic [31:0] c, input int i);
    return PA_W'({c[31:5], 2'(i), 3'b000});
  endfunction

  task automatic fill(input logic [31:0] c, input int first);
    for (int i = 0; i < 4; i++) mem[{c[9:5], 2'(i)}] = VEC[first + i][63:0];
  endtask

  task automatic pulse(input int kind);
    @(negedge clk);
    case (kind)
      0: cr3_wr_i = 1'b1;
      1: task_sw_i = 1'b1;
      default: ctl_wr_i = 1'b1;
    endcase
    @(negedge clk);
    cr3_wr_i = 1'b0; task_sw_i = 1'b0; ctl_wr_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 400 && busy_o; k++) @(negedge clk);
  endtask

  task automatic check_table(input int first, input string req);
    for (int i = 0; i < 4; i++) begin
      check(ent_o[i] == VEC[first + i][63:0], req, ent_o[i], VEC[first + i][63:0]);
      check(ent_vld_o[i] == VEC[first + i][65], "R6 vld", 64'(ent_vld_o[i]), 64'(VEC[first + i][65]));
      check(ent_flt_o[i] == VEC[first + i][64], "R6 flt", 64'(ent_flt_o[i]), 64'(VEC[first + i][64]));
    end
  endtask

  // memory responder: answers the address on the port after lat cycles
  initial begin
    logic [PA_W-1:0] last;
    int cnt;
    last = '0; cnt = 0;
    forever begin
      @(negedge clk);
      if (!rd_req_o || rd_addr_o != last || rd_valid_i) begin
        rd_valid_i = 1'b0;
        last = rd_addr_o;
        cnt = 0;
      end else begin
        cnt++;
        if (cnt >= lat) begin
          rd_valid_i = 1'b1;
          rd_data_i = mem[rd_addr_o[9:3]];
          alog[nlog % 256] = rd_addr_o;
          nlog++;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tot++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end

  initial begin
    logic [63:0] snap;
    int base_log;
    for (int i = 0; i < 128; i++) mem[i] = {32'hA5A5_0000, 32'(i)} << 12 | 64'h1;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!busy_o && !rd_req_o, "R9 busy/req", 64'({busy_o, rd_req_o}), 64'h0);
    check(ent_vld_o == 0 && ent_flt_o == 0, "R9 flags", 64'({ent_vld_o, ent_flt_o}), 64'h0);
    check(ent_o == '0, "R9 data", ent_o[0], 64'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    // table walk: R1 addresses, R6 classification
    for (int t = 0; t < 3; t++) begin
      fill(CR3S[t], 4 * t);
      cr3_i = CR3S[t];
      base_log = nlog;
      pulse(0);
      check(busy_o == 1'b1, "R5 busy", 64'(busy_o), 64'h1);
      wait_idle();
      check_table(4 * t, "R1 data");
      for (int i = 0; i < 4; i++)
        check(alog[(base_log + i) % 256] == exp_addr(CR3S[t], i), "R1 addr",
              64'(alog[(base_log + i) % 256]), 64'(exp_addr(CR3S[t], i)));
    end

    // R8: memory changes, no trigger
    snap = ent_o[2];
    mem[{CR3S[2][9:5], 2'd2}] = 64'h1111_0001;
    repeat (20) @(negedge clk);
    check(ent_o[2] == snap && !rd_req_o, "R8 hold", ent_o[2], snap);

    // R2: ignored outside PAE mode
    long_mode_i = 1'b1; pulse(0);
    check(!busy_o && !rd_req_o, "R2 long mode", 64'(busy_o), 64'h0);
    long_mode_i = 1'b0; pae_en_i = 1'b0; pulse(0);
    check(!busy_o && ent_o[2] == snap, "R2 pae off", ent_o[2], snap);
    pae_en_i = 1'b1;

    // R3: task switch
    paging_en_i = 1'b0; pulse(1);
    check(!busy_o, "R3 paging off", 64'(busy_o), 64'h0);
    paging_en_i = 1'b1;
    fill(CR3S[0], 4); cr3_i = CR3S[0];
    pulse(1);
    check(busy_o && ent_vld_o == 0 && ent_flt_o == 0, "R5 clear", 64'({ent_vld_o, ent_flt_o}), 64'h0);
    wait_idle();
    check_table(4, "R3 data");

    // R4: control write
    ctl_old_i = 7'h55; ctl_new_i = 7'h55; pulse(2);
    check(!busy_o, "R4 no change", 64'(busy_o), 64'h0);
    long_mode_i = 1'b1; ctl_new_i = 7'h54; pulse(2);
    check(!busy_o, "R4 outside pae", 64'(busy_o), 64'h0);
    long_mode_i = 1'b0;
    for (int b = 0; b < 7; b++) begin
      ctl_old_i = '0; ctl_new_i = 7'(1 << b);
      pulse(2);
      check(busy_o == 1'b1, "R4 bit change", 64'(b), 64'h1);
      wait_idle();
    end

    // R7: restart mid-refill with a new base
    lat = 3;
    fill(CR3S[1], 0); fill(CR3S[2], 8);
    cr3_i = CR3S[1]; base_log = nlog;
    pulse(0);
    for (int k = 0; k < 100 && nlog < base_log + 2; k++) @(negedge clk);
    @(negedge clk);
    cr3_i = CR3S[2]; base_log = nlog;
    pulse(0);
    check(rd_req_o && rd_addr_o == exp_addr(CR3S[2], 0), "R7 restart addr",
          64'(rd_addr_o), 64'(exp_addr(CR3S[2], 0)));
    wait_idle();
    check(!busy_o && !rd_req_o, "R5 done", 64'({busy_o, rd_req_o}), 64'h0);
    check_table(8, "R7 data");
    check(nlog - base_log == 4, "R7 count", 64'(nlog - base_log), 64'd4);

    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end
endmodule